// File: doc/BRIEF.md
# Two-Wire Register Write Master

This block writes one byte into a register of a video decoder over a two-wire serial bus. The host presents a register index and a data value, selects one of two device addresses with a strap input, and pulses a start request. The block then puts a complete write frame on the bus. The frame is a start condition, the device address byte, the register index byte, the data byte, and a stop condition. Each byte is followed by an acknowledge clock.

The block drives SCL directly. It controls SDA as an open-drain line: the `sda_oe` output pulls the wire low and an external pull-up supplies the high level. The block reads the wire back on `sda_i`. Every bit cell lasts `CLK_DIV` system clocks and is split into four equal quarters. The quarters decide when SDA may move and when SCL rises and falls.

A missing acknowledge ends the frame early with a stop condition and raises an error flag. A one-cycle `done` pulse marks the end of every frame, whether it completed or was aborted.

Top module: `cfg_wire_writer`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe` is 0, and `busy`, `done` and `ack_err` are all 0.
- R2: Each frame opens with exactly one start condition: SDA falls while SCL stays high.
- R3: Apart from the start and the stop, SDA changes only while SCL is low. The bus therefore shows exactly two SDA transitions under a high SCL per frame.
- R4: The bytes go out in a fixed order: device address, then register index, then data. Every byte is sent most significant bit first, one bit per SCL high phase.
- R5: The device address byte is 0x48 when `req_strap` is 1 and 0x4A when it is 0. Bit 0 is the write bit and is 0.
- R6: During the ninth SCL clock of each byte the master releases SDA (`sda_oe` is 0), so the receiver can drive the acknowledge.
- R7: If SDA reads high in the ninth clock of a byte, `ack_err` is set. The frame then moves straight to the stop condition, and no later byte is sent.
- R8: Each frame closes with a stop condition: SDA rises while SCL is high. After it, the bus is left with SCL high and SDA released.
- R9: `busy` rises in the cycle after the accepting clock edge. It stays high for exactly (2 + 9·n)·`CLK_DIV` cycles, where n is the number of bytes sent. `done` is high for one cycle, the first cycle in which `busy` is low again.
- R10: Start requests that arrive while `busy` is high are ignored. They change neither the frame in progress nor the bus afterwards.
- R11: During a frame, consecutive SCL rising edges are exactly `CLK_DIV` system clocks apart.
- R12: `ack_err` keeps its value after a frame and clears when the next start request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | Start request, accepted only while idle |
| req_strap | input | 1 | Device address select (1: 0x48, 0: 0x4A) |
| req_subaddr | input | 8 | Register index to write |
| req_data | input | 8 | Value to write |
| sda_i | input | 1 | Level read back from the SDA wire |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| ack_err | output | 1 | Missing acknowledge in the last frame |

## Verification
A frame's results fall due at fixed cycles after the accepting edge.
- `busy` rises one cycle after that edge.
- `done` arrives exactly (2 + 9·n)·`CLK_DIV` cycles later.
- The bus pins lag the internal sequencer by one register.

The checks sample on falling clock edges only, so each comparison sees settled values. The bench counts `busy` samples to confirm the exact frame length. It waits for the `done` pulse before it compares the captured bytes, the number of start and stop events and the error flag. The pulse-width check and the idle-bus checks are made on the samples that follow `done`.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BIT   = 2'd2,
    ST_STOP  = 2'd3
  } seq_state_t;

  localparam int          BYTE_W        = 8;
  localparam int          FRAME_BYTES   = 3;
  localparam int          ACK_SLOT      = 8;
  localparam logic [7:0]  DEV_ADDR_HI   = 8'h48;
  localparam logic [7:0]  DEV_ADDR_LO   = 8'h4A;
endpackage

// File: rtl/cfgw_phase_gen.sv
module cfgw_phase_gen #(
  parameter int QUARTER = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic       tick,
  output logic [1:0] quarter
);
  localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(QUARTER - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      quarter <= 2'd0;
    end else if (tick) begin
      cnt     <= '0;
      quarter <= quarter + 2'd1;
    end else begin
      cnt     <= cnt + CW'(1);
    end
  end

  // R11
  quarter_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (quarter == $past(quarter) + 2'd1));
endmodule

// File: rtl/cfgw_frame_store.sv
module cfgw_frame_store #(
  parameter int NUM_BYTES = 3,
  parameter int BYTE_W    = 8,
  localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              busy,
  input  logic [BYTE_W-1:0] load_bytes [NUM_BYTES],
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [3:0]        bit_idx,
  output logic              bit_val
);
  logic [BYTE_W-1:0] bytes_q [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        bytes_q[g] <= '0;
      else if (load)
        bytes_q[g] <= load_bytes[g];
    end

    // R10
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(bytes_q[g]));
  end

  always_comb begin
    bit_val = 1'b1;
    if (int'(bit_idx) < BYTE_W)
      bit_val = bytes_q[byte_idx][BYTE_W - 1 - int'(bit_idx)];
  end
endmodule

// File: rtl/cfgw_seq.sv
module cfgw_seq
  import cfgw_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic             tick,
  input  logic [1:0]       quarter,
  input  logic             sda_i,
  input  logic             bit_val,
  output logic             load,
  output logic             busy,
  output logic             done,
  output logic             ack_err,
  output logic             scl_c,
  output logic             pull_low_c,
  output logic [IDX_W-1:0] byte_idx,
  output logic [3:0]       bit_idx
);
  seq_state_t state;
  logic       nack;
  logic       last_byte;
  logic       in_ack;

  assign load      = (state == ST_IDLE) && req_start;
  assign busy      = (state != ST_IDLE);
  assign last_byte = (byte_idx == IDX_W'(NUM_BYTES - 1));
  assign in_ack    = (bit_idx == 4'(ACK_SLOT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      byte_idx <= '0;
      bit_idx  <= '0;
      nack     <= 1'b0;
      ack_err  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_start) begin
            state    <= ST_START;
            ack_err  <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= '0;
            nack     <= 1'b0;
          end
        end
        ST_START: begin
          if (tick && quarter == 2'd3)
            state <= ST_BIT;
        end
        ST_BIT: begin
          if (tick) begin
            if (quarter == 2'd2 && in_ack) begin
              nack <= sda_i;
              if (sda_i)
                ack_err <= 1'b1;
            end
            if (quarter == 2'd3) begin
              if (in_ack) begin
                bit_idx <= '0;
                if (nack || last_byte)
                  state <= ST_STOP;
                else
                  byte_idx <= byte_idx + IDX_W'(1);
              end else begin
                bit_idx <= bit_idx + 4'd1;
              end
            end
          end
        end
        ST_STOP: begin
          if (tick && quarter == 2'd3) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_c      = 1'b1;
    pull_low_c = 1'b0;
    unique case (state)
      ST_IDLE: begin
        scl_c      = 1'b1;
        pull_low_c = 1'b0;
      end
      ST_START: begin
        scl_c      = (quarter != 2'd3);
        pull_low_c = (quarter != 2'd0);
      end
      ST_BIT: begin
        scl_c      = (quarter == 2'd1) || (quarter == 2'd2);
        pull_low_c = !in_ack && !bit_val;
      end
      ST_STOP: begin
        scl_c      = (quarter != 2'd0);
        pull_low_c = (quarter == 2'd0) || (quarter == 2'd1);
      end
      default: ;
    endcase
  end

  // R7
  nack_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BIT && tick && quarter == 2'd3 && in_ack && nack)
      |=> (state == ST_STOP && ack_err));

  // R9
  done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE && $past(state) == ST_STOP));
endmodule

// File: rtl/cfg_wire_writer.sv
module cfg_wire_writer
  import cfgw_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_strap,
  input  logic [BYTE_W-1:0] req_subaddr,
  input  logic [BYTE_W-1:0] req_data,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic              ack_err
);
  localparam int QUARTER = (CLK_DIV >= 4) ? CLK_DIV / 4 : 1;
  localparam int IDX_W   = $clog2(FRAME_BYTES);

  logic              tick;
  logic [1:0]        quarter;
  logic              load;
  logic              bit_val;
  logic              scl_c;
  logic              pull_low_c;
  logic [IDX_W-1:0]  byte_idx;
  logic [3:0]        bit_idx;
  logic [BYTE_W-1:0] frame_bytes [FRAME_BYTES];

  assign frame_bytes[0] = req_strap ? DEV_ADDR_HI : DEV_ADDR_LO;
  assign frame_bytes[1] = req_subaddr;
  assign frame_bytes[2] = req_data;

  cfgw_phase_gen #(.QUARTER(QUARTER)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .tick    (tick),
    .quarter (quarter)
  );

  cfgw_frame_store #(.NUM_BYTES(FRAME_BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .busy       (busy),
    .load_bytes (frame_bytes),
    .byte_idx   (byte_idx),
    .bit_idx    (bit_idx),
    .bit_val    (bit_val)
  );

  cfgw_seq #(.NUM_BYTES(FRAME_BYTES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_start  (req_start),
    .tick       (tick),
    .quarter    (quarter),
    .sda_i      (sda_i),
    .bit_val    (bit_val),
    .load       (load),
    .busy       (busy),
    .done       (done),
    .ack_err    (ack_err),
    .scl_c      (scl_c),
    .pull_low_c (pull_low_c),
    .byte_idx   (byte_idx),
    .bit_idx    (bit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_o  <= 1'b1;
      sda_oe <= 1'b0;
    end else begin
      scl_o  <= scl_c;
      sda_oe <= pull_low_c;
    end
  end

  // R8
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (scl_o && !sda_oe));
endmodule

// File: tb/cfg_wire_writer_test.sv
module cfg_wire_writer_test;
  localparam int CLK_DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_start = 1'b0;
  logic       req_strap = 1'b0;
  logic [7:0] req_subaddr = '0;
  logic [7:0] req_data = '0;
  logic       scl_o, sda_oe, busy, done, ack_err;
  logic       slave_drv = 1'b0;
  logic       sda_line;
  logic       mon_clear = 1'b0;
  logic [2:0] ack_en = 3'b111;

  assign sda_line = !(sda_oe || slave_drv);

  always #2 clk = ~clk;

  cfg_wire_writer #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_strap(req_strap),
    .req_subaddr(req_subaddr), .req_data(req_data), .sda_i(sda_line),
    .scl_o(scl_o), .sda_oe(sda_oe), .busy(busy), .done(done), .ack_err(ack_err)
  );

  // bus monitor and acknowledging receiver
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         n_start, n_stop, bitcnt, ncap, busy_cyc, gap, rise_min, rise_max, ack_viol;
  logic       seen_rise;
  logic [7:0] shreg;
  logic [7:0] cap [4];

  always @(negedge clk) begin
    if (mon_clear) begin
      n_start = 0; n_stop = 0; bitcnt = 0; ncap = 0; busy_cyc = 0;
      gap = 0; rise_min = 1000; rise_max = 0; ack_viol = 0; seen_rise = 1'b0;
      slave_drv = 1'b0;
    end else begin
      gap++;
      if (busy) busy_cyc++;
      if (p_scl && scl_o && p_sda && !sda_line) begin
        n_start++; bitcnt = 0; ncap = 0;
      end
      if (p_scl && scl_o && !p_sda && sda_line) n_stop++;
      if (!p_scl && scl_o) begin
        if (seen_rise) begin
          if (gap < rise_min) rise_min = gap;
          if (gap > rise_max) rise_max = gap;
        end
        seen_rise = 1'b1; gap = 0;
        if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
        if (bitcnt == 8 && sda_oe) ack_viol++;
        bitcnt++;
      end
      if (p_scl && !scl_o) begin
        if (bitcnt == 8 && ncap < 3) begin
          cap[ncap] = shreg;
          slave_drv = ack_en[ncap];
        end else if (bitcnt == 9) begin
          slave_drv = 1'b0; ncap++; bitcnt = 0;
        end
      end
    end
    p_scl = scl_o; p_sda = sda_line;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic kick(input logic s, input logic [7:0] sub, input logic [7:0] dat,
                      input logic [2:0] mask);
    @(posedge clk); #1;
    req_strap = s; req_subaddr = sub; req_data = dat; ack_en = mask;
    req_start = 1'b1; mon_clear = 1'b1;
    @(posedge clk); #1;
    req_start = 1'b0; mon_clear = 1'b0;
  endtask

  task automatic wait_done();
    bit got = 0;
    for (int c = 0; c < 5000 && !got; c++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    if (!got) chk("watchdog: done never seen", 0, 1);
  endtask

  // {strap, subaddr, data, ack mask (bit k = byte k acked), bytes sent, error}
  localparam logic [22:0] VEC [6] = '{
    {1'b1, 8'h1F, 8'hA5, 3'b111, 2'd3, 1'b0},
    {1'b0, 8'h02, 8'hC0, 3'b111, 2'd3, 1'b0},
    {1'b1, 8'h80, 8'h01, 3'b110, 2'd1, 1'b1},
    {1'b0, 8'h55, 8'hFF, 3'b101, 2'd2, 1'b1},
    {1'b1, 8'h0A, 8'h3C, 3'b011, 2'd3, 1'b1},
    {1'b0, 8'hFE, 8'h00, 3'b111, 2'd3, 1'b0}
  };

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_o", int'(scl_o), 1);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ack_err", int'(ack_err), 0);

    for (int i = 0; i < 6; i++) begin
      logic [22:0] v;
      logic [7:0]  exp_b [3];
      int          nb;
      v = VEC[i];
      nb = int'(v[2:1]);
      exp_b[0] = v[22] ? 8'h48 : 8'h4A;
      exp_b[1] = v[21:14];
      exp_b[2] = v[13:6];
      kick(v[22], v[21:14], v[13:6], v[5:3]);
      wait_done();
      chk("R7 bytes sent", ncap, nb);
      chk("R5 device address byte", int'(cap[0]), int'(exp_b[0]));
      for (int b = 1; b < nb; b++) chk("R4 byte order/MSB first", int'(cap[b]), int'(exp_b[b]));
      chk("R7 ack_err", int'(ack_err), int'(v[0]));
      chk("R2 start count", n_start, 1);
      chk("R3 high-SCL SDA events", n_start + n_stop, 2);
      chk("R6 master released on ack clock", ack_viol, 0);
      chk("R9 busy length", busy_cyc, (2 + 9 * nb) * CLK_DIV);
      chk("R11 SCL period min", rise_min, CLK_DIV);
      chk("R11 SCL period max", rise_max, CLK_DIV);
      chk("R8 stop seen", n_stop, 1);
      chk("R8 scl idle high", int'(scl_o), 1);
      chk("R8 sda released", int'(sda_oe), 0);
      @(negedge clk);
      chk("R9 done one cycle", int'(done), 0);
      chk("R12 ack_err held", int'(ack_err), int'(v[0]));
    end

    // R12: error from a refused frame clears on the next accepted start
    kick(1'b1, 8'h11, 8'h22, 3'b000);
    wait_done();
    chk("R12 error set", int'(ack_err), 1);
    kick(1'b1, 8'h11, 8'h22, 3'b111);
    repeat (20) @(negedge clk);
    chk("R12 error cleared on start", int'(ack_err), 0);
    wait_done();
    chk("R12 error stays clear", int'(ack_err), 0);

    // R10: start request during a frame is ignored
    kick(1'b0, 8'h3C, 8'h96, 3'b111);
    repeat (100) @(posedge clk);
    #1; req_strap = 1'b1; req_subaddr = 8'h77; req_data = 8'h66; req_start = 1'b1;
    @(posedge clk); #1; req_start = 1'b0;
    wait_done();
    chk("R10 address kept", int'(cap[0]), 8'h4A);
    chk("R10 subaddr kept", int'(cap[1]), 8'h3C);
    chk("R10 data kept", int'(cap[2]), 8'h96);
    begin
      int hi = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (busy) hi++;
      end
      chk("R10 no second frame busy", hi, 0);
      chk("R10 no second start", n_start, 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule